// File: doc/BRIEF.md
# Key-Combination Reset Detector

This block turns a chord of key presses into a system reset request. It runs on a slow, watch-crystal-rate clock and watches four active-low key lines. A static selection input picks which of the lines make up the chord, or switches the feature off. A reset is requested only after every line in the chord has been held low together for a set number of clock cycles. This hold filter rejects short glitches and short, accidental chords.

The hold filter runs only while the oscillator reports that it is running. The full hold time is therefore measured again from the moment the oscillator comes up. An optional authorization stage adds a much longer wait. It counts edges of a free-running tick that is divided down from the clock. The request is raised on the second tick edge seen while the filtered chord holds, which gives a delay of between one and two tick periods.

The request is a level. It stays high while the chord is held and drops on the edge after any selected key is released.

Top module: `kcr_detector`

## Requirements
- R1: While `rst` is high, and on the edge after it, `rst_req` is low.
- R2: With `cfg_sel` = 0 the feature is off: `rst_req` stays low whatever the key levels.
- R3: With `cfg_sel` = 1 the chord is keys_n[3:0] all low; with only three of them low, no request is made.
- R4: With `cfg_sel` = 2 the chord is keys_n[2:0] all low; keys_n[3] has no effect in either state, including while a request is active.
- R5: With `cfg_sel` = 3 the chord is keys_n[1:0] all low; keys_n[3:2] have no effect.
- R6: With `auth_en` low, `rst_req` rises on the (NR_CYCLES+1)-th rising edge after the chord is first sampled complete, and not earlier.
- R7: While `osc_run` is low, no request is made and the hold count is held at zero. After `osc_run` rises, the full hold of R6 is required again.
- R8: With `auth_en` high, `rst_req` rises no earlier than edge NR_CYCLES+TICK_DIV+2 and no later than edge NR_CYCLES+2*TICK_DIV+1, both counted from the start of the chord.
- R9: Once raised, `rst_req` falls on the first edge after any selected key reads high.
- R10: A release of the chord before qualification restarts all counting from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Low-speed sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_run | input | 1 | High once the oscillator is running |
| keys_n | input | 4 | Active-low key lines |
| cfg_sel | input | 2 | Chord selection: 0 off, 1 keys 0-3, 2 keys 0-2, 3 keys 0-1 |
| auth_en | input | 1 | Enables the long authorization wait |
| rst_req | output | 1 | Reset request level |

## Verification
An incorrect internal count can be seen at the ports as a request edge that lands in the wrong cycle. If the hold counter is wrong, the request rises before or after edge NR_CYCLES+1, and the exact-edge checks catch this. If the tick or authorization counter is wrong, the request appears outside its one-to-two-period window, and the checks bracket that window from both sides. If a counter is not cleared on release or while the oscillator is off, the request comes early on the next chord. For this reason each chord is placed right after a glitch or an oscillator restart.

// File: rtl/kcr_pkg.sv
package kcr_pkg;

    localparam int N_KEYS = 4;

    typedef enum logic [1:0] {
        CHORD_OFF  = 2'd0,
        CHORD_K0_3 = 2'd1,
        CHORD_K0_2 = 2'd2,
        CHORD_K0_1 = 2'd3
    } chord_sel_e;

    typedef struct packed {
        logic held;     // chord complete and oscillator up
        logic filtered; // hold filter satisfied
        logic authed;   // authorization wait satisfied
    } qual_t;

    function automatic logic [N_KEYS-1:0] chord_mask(input chord_sel_e sel);
        case (sel)
            CHORD_K0_3: chord_mask = 4'b1111;
            CHORD_K0_2: chord_mask = 4'b0111;
            CHORD_K0_1: chord_mask = 4'b0011;
            default:    chord_mask = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/kcr_chord_decode.sv
module kcr_chord_decode
    import kcr_pkg::*;
(
    input  logic [N_KEYS-1:0] keys_n,
    input  logic [1:0]        cfg_sel,
    output logic              chord
);
    logic [N_KEYS-1:0] mask;
    logic [N_KEYS-1:0] pressed;

    always_comb begin
        mask    = chord_mask(chord_sel_e'(cfg_sel));
        pressed = ~keys_n;
        chord   = (mask != '0) && ((pressed & mask) == mask);
    end
endmodule

// File: rtl/kcr_hold_filter.sv
module kcr_hold_filter #(
    parameter int NR_CYCLES = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic held,
    output logic passed
);
    localparam int CW = $clog2(NR_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(NR_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !held) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb passed = held && (cnt == LIMIT);
endmodule

// File: rtl/kcr_tick_gen.sv
module kcr_tick_gen #(
    parameter int TICK_DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

    logic [TW-1:0] div;

    always_ff @(posedge clk) begin
        if (rst || div == LAST) begin
            div <= '0;
        end else begin
            div <= div + 1'b1;
        end
    end

    always_comb tick = (div == LAST);
endmodule

// File: rtl/kcr_auth_timer.sv
module kcr_auth_timer (
    input  logic clk,
    input  logic rst,
    input  logic filtered,
    input  logic tick,
    output logic authed
);
    logic [1:0] edges;

    always_ff @(posedge clk) begin
        if (rst || !filtered) begin
            edges <= 2'd0;
        end else if (tick && edges != 2'd2) begin
            edges <= edges + 2'd1;
        end
    end

    always_comb authed = filtered && (edges == 2'd2);
endmodule

// File: rtl/kcr_detector.sv
module kcr_detector
    import kcr_pkg::*;
#(
    parameter int NR_CYCLES = 50,
    parameter int TICK_DIV  = 32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_run,
    input  logic [N_KEYS-1:0] keys_n,
    input  logic [1:0]        cfg_sel,
    input  logic              auth_en,
    output logic              rst_req
);
    logic  chord;
    logic  tick;
    qual_t q;

    kcr_chord_decode u_dec (
        .keys_n (keys_n),
        .cfg_sel(cfg_sel),
        .chord  (chord)
    );

    always_comb q.held = chord && osc_run;

    kcr_hold_filter #(.NR_CYCLES(NR_CYCLES)) u_flt (
        .clk   (clk),
        .rst   (rst),
        .held  (q.held),
        .passed(q.filtered)
    );

    kcr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    kcr_auth_timer u_auth (
        .clk     (clk),
        .rst     (rst),
        .filtered(q.filtered),
        .tick    (tick),
        .authed  (q.authed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= auth_en ? q.authed : q.filtered;
        end
    end
endmodule

// File: rtl/kcr_detector_chk.sv
module kcr_detector_chk #(
    parameter int NR_CYCLES = 50,
    parameter int TICK_DIV  = 32768
) (
    input logic       clk,
    input logic       rst,
    input logic       osc_run,
    input logic [3:0] keys_n,
    input logic [1:0] cfg_sel,
    input logic       auth_en,
    input logic       rst_req
);
    localparam int HMAX = NR_CYCLES + TICK_DIV + 2;
    localparam int HW   = $clog2(HMAX + 1);
    localparam logic [HW-1:0] HLIM  = HW'(HMAX);
    localparam logic [HW-1:0] HFILT = HW'(NR_CYCLES + 1);

    logic [3:0]    sel;
    logic          full;
    logic [HW-1:0] hold;

    always_comb begin
        case (cfg_sel)
            2'd1:    sel = 4'b1111;
            2'd2:    sel = 4'b0111;
            2'd3:    sel = 4'b0011;
            default: sel = 4'b0000;
        endcase
        full = (sel != 4'b0) && ((keys_n & sel) == 4'b0);
    end

    always_ff @(posedge clk) begin
        if (rst || !(full && osc_run)) hold <= '0;
        else if (hold != HLIM)        hold <= hold + 1'b1;
    end

    a_r1_reset_clear: assert property (@(posedge clk) rst |=> !rst_req);

    a_r2_disabled: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel == 2'd0) |=> !rst_req);

    a_r7_osc_gate: assert property (@(posedge clk) disable iff (rst)
        !osc_run |=> !rst_req);

    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        !full |=> !rst_req);

    a_r6_min_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> (hold >= HFILT));

    a_r8_min_auth: assert property (@(posedge clk) disable iff (rst)
        (auth_en && $rose(rst_req)) |-> (hold == HLIM));
endmodule

bind kcr_detector kcr_detector_chk #(
    .NR_CYCLES(NR_CYCLES),
    .TICK_DIV (TICK_DIV)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .osc_run(osc_run),
    .keys_n (keys_n),
    .cfg_sel(cfg_sel),
    .auth_en(auth_en),
    .rst_req(rst_req)
);

// File: tb/sim_kcr_detector.sv
module sim_kcr_detector;
    localparam int CLK_PER = 10;
    localparam int NR      = 50;
    localparam int TD      = 200;

    logic       clk = 1'b0;
    logic       rst;
    logic       osc_run;
    logic [3:0] keys_n;
    logic [1:0] cfg_sel;
    logic       auth_en;
    logic       rst_req;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PER/2) clk = ~clk;

    kcr_detector #(.NR_CYCLES(NR), .TICK_DIV(TD)) u0 (
        .clk    (clk),
        .rst    (rst),
        .osc_run(osc_run),
        .keys_n (keys_n),
        .cfg_sel(cfg_sel),
        .auth_en(auth_en),
        .rst_req(rst_req)
    );

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic exp);
        total++;
        if (rst_req !== exp) begin
            bad++;
            $display("FAIL %s: rst_req actual=%b expected=%b at %0t", req, rst_req, exp, $time);
        end
    endtask

    task automatic idle();
        keys_n = 4'hF;
        edges(3);
    endtask

    task automatic t_reset();
        rst = 1'b1; osc_run = 1'b1; keys_n = 4'hF; cfg_sel = 2'd1; auth_en = 1'b0;
        edges(4);
        check("R1 during reset", 1'b0);
        rst = 1'b0;
        edges(1);
        check("R1 after reset", 1'b0);
    endtask

    task automatic t_disabled();
        cfg_sel = 2'd0; keys_n = 4'h0;
        edges(NR + 10);
        check("R2 off with all keys low", 1'b0);
        idle();
    endtask

    task automatic t_mode1();
        cfg_sel = 2'd1; keys_n = 4'b1000;
        edges(NR + 10);
        check("R3 three of four low", 1'b0);
        idle();
        keys_n = 4'b0000;
        edges(NR);
        check("R6 one edge before qualify", 1'b0);
        edges(1);
        check("R6 qualify edge", 1'b1);
        keys_n = 4'b1000;
        edges(1);
        check("R9 drop after key3 release", 1'b0);
        idle();
    endtask

    task automatic t_mode2();
        cfg_sel = 2'd2; keys_n = 4'b1000;
        edges(NR + 1);
        check("R4 keys 0-2 low, key3 high", 1'b1);
        keys_n = 4'b0000;
        edges(2);
        check("R4 key3 low keeps request", 1'b1);
        keys_n = 4'b1000;
        edges(2);
        check("R4 key3 high keeps request", 1'b1);
        keys_n = 4'b1100;
        edges(1);
        check("R9 drop after key2 release", 1'b0);
        idle();
    endtask

    task automatic t_mode3();
        cfg_sel = 2'd3; keys_n = 4'b1100;
        edges(NR);
        check("R5 before qualify", 1'b0);
        edges(1);
        check("R5 keys 0-1 low qualify", 1'b1);
        keys_n = 4'b0110;
        edges(1);
        check("R9 drop after key1 release", 1'b0);
        idle();
    endtask

    task automatic t_glitch();
        cfg_sel = 2'd1; keys_n = 4'h0;
        edges(NR - 5);
        keys_n = 4'b0001;
        edges(1);
        keys_n = 4'h0;
        edges(NR);
        check("R10 restart after glitch", 1'b0);
        edges(1);
        check("R10 full hold after glitch", 1'b1);
        idle();
    endtask

    task automatic t_osc();
        cfg_sel = 2'd1; osc_run = 1'b0; keys_n = 4'h0;
        edges(NR + 10);
        check("R7 no request while osc down", 1'b0);
        osc_run = 1'b1;
        edges(NR);
        check("R7 full hold after osc start", 1'b0);
        edges(1);
        check("R7 qualify after osc start", 1'b1);
        idle();
    endtask

    task automatic t_auth();
        cfg_sel = 2'd1; auth_en = 1'b1; keys_n = 4'h0;
        edges(NR + 1);
        check("R8 no request at filter time", 1'b0);
        edges(TD);
        check("R8 before earliest bound", 1'b0);
        edges(TD);
        check("R8 by latest bound", 1'b1);
        keys_n = 4'b0100;
        edges(1);
        check("R9 drop with auth", 1'b0);
        idle();
        keys_n = 4'h0;
        edges(NR + TD);
        keys_n = 4'b1111;
        edges(1);
        keys_n = 4'h0;
        edges(NR + TD + 1);
        check("R10 auth restart after release", 1'b0);
        idle();
        auth_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_mode1();
        t_mode2();
        t_mode3();
        t_glitch();
        t_osc();
        t_auth();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule